// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block runs one access at a time to an external asynchronous memory. It is a RAM-like device with a chip select, separate read and write strobes, an address bus and a shared data bus. A request carries a direction, an address and write data. The block accepts it when it is free. It then holds chip select low for a programmed number of system clock cycles. Inside that window it pulses the read or write strobe at a programmed offset and for a programmed width.

The read direction and the write direction each have their own triple of counts: setup, pulse and cycle length. The hold time after the strobe rises is not programmed. It is whatever remains of the cycle once setup and pulse are taken out. A read captures the data bus on the edge where the read strobe rises.

After a read, a separate turnaround count keeps the block from starting a new access. This leaves the device time to release the shared bus. A count set whose setup plus pulse overruns the cycle length is flagged, and the cycle is lengthened so that at least one hold cycle remains.

Top module: `smem_strobe_gen`

## Requirements
- R1: During and right after reset, mem_cs_n, mem_rd_n and mem_wr_n are 1, mem_doe is 0, rsp_done is 0, cfg_err is 0 and req_ready is 1.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. Chip select is low from the next cycle for exactly L consecutive cycles. L is the effective cycle length of the selected direction (see R10).
- R3: Number the access cycles k = 0 .. L-1. The strobe of the access direction is low exactly for S <= k < S+P, where S is the setup count and P is the pulse count, with a pulse count of 0 taken as 1. mem_rd_n is the read strobe (req_write=0) and mem_wr_n is the write strobe (req_write=1). The strobe of the other direction stays 1.
- R4: Between the cycle in which the strobe returns high and the end of chip select, L-S-P hold cycles pass, with chip select still low.
- R5: mem_addr equals the accepted address, and mem_dout the accepted write data, for every cycle of chip select. mem_doe is 1 for every cycle of a write access and 0 during reads and while idle.
- R6: For a read, rsp_rdata takes the mem_din value present in cycle k = S+P-1 and keeps it until the next read captures. Writes leave rsp_rdata unchanged.
- R7: rsp_done is 1 for exactly one cycle: the cycle right after the last chip-select cycle of each access.
- R8: After a read, req_ready stays 0 for F cycles, starting with the rsp_done cycle. F is the value of cfg_float at the last chip-select cycle. After a write, req_ready is 1 in the rsp_done cycle.
- R9: Reads use only cfg_rd_setup, cfg_rd_pulse and cfg_rd_cycle. Writes use only the cfg_wr_* counts. All counts are sampled at acceptance.
- R10: If S+P is greater than the programmed cycle count C, then L = S+P+1 and cfg_err is 1 during every chip-select cycle of that access. Otherwise L = C and cfg_err stays 0.
- R11: While req_ready is 0, req_valid and all request fields have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rd_setup | input | CNT_W | Read setup count |
| cfg_rd_pulse | input | CNT_W | Read strobe width |
| cfg_rd_cycle | input | CNT_W | Read total cycle count |
| cfg_wr_setup | input | CNT_W | Write setup count |
| cfg_wr_pulse | input | CNT_W | Write strobe width |
| cfg_wr_cycle | input | CNT_W | Write total cycle count |
| cfg_float | input | CNT_W | Turnaround cycles after a read |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| req_ready | output | 1 | Block can accept a request this cycle |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_addr | output | AW | Address to the device |
| mem_dout | output | DW | Write data to the device |
| mem_doe | output | 1 | Drive enable for mem_dout |
| mem_din | input | DW | Read data from the device |
| rsp_rdata | output | DW | Captured read data |
| rsp_done | output | 1 | One-cycle access completion pulse |
| cfg_err | output | 1 | Current access had an overrun count set |

## Verification
The bench first runs the nominal 1/3/5 timing with a turnaround of 2, using mixed directions and a request held on every cycle. This separates correct strobe placement and turnaround from off-by-one errors in hold or float. Zero setup and zero pulse with a zero cycle count, and setup plus pulse equal to the cycle count, probe the pulse-floor rule and the stretch/no-stretch boundary. An overrun set and a maximum-length cycle exercise the error flag and the widest counters.

Distinct read and write count sets catch a swapped selection. A mem_din value that changes every cycle shows any capture on the wrong edge. Idle gaps with requests toggled during busy and turnaround periods show whether requests leak through.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } smem_dir_e;
endpackage

// File: rtl/smem_cfg_sel.sv
module smem_cfg_sel #(
  parameter int CNT_W = 4,
  parameter int LEN_W = CNT_W + 2
) (
  input  logic             dir_i,
  input  logic [CNT_W-1:0] rd_setup_i,
  input  logic [CNT_W-1:0] rd_pulse_i,
  input  logic [CNT_W-1:0] rd_cycle_i,
  input  logic [CNT_W-1:0] wr_setup_i,
  input  logic [CNT_W-1:0] wr_pulse_i,
  input  logic [CNT_W-1:0] wr_cycle_i,
  output logic [LEN_W-1:0] setup_o,
  output logic [LEN_W-1:0] pend_o,
  output logic [LEN_W-1:0] len_o,
  output logic             over_o
);
  import smem_pkg::*;

  function automatic logic [LEN_W-1:0] eff_pulse(input logic [CNT_W-1:0] p);
    return (p == '0) ? LEN_W'(1) : LEN_W'(p);
  endfunction

  function automatic logic overrun(input logic [LEN_W-1:0] strobe_end,
                                   input logic [CNT_W-1:0] c);
    return strobe_end > LEN_W'(c);
  endfunction

  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] strobe_end,
                                               input logic [CNT_W-1:0] c);
    return overrun(strobe_end, c) ? strobe_end + LEN_W'(1) : LEN_W'(c);
  endfunction

  logic [CNT_W-1:0] s_sel, p_sel, c_sel;
  logic [LEN_W-1:0] end_sel;

  always_comb begin
    if (smem_dir_e'(dir_i) == DIR_WR) begin
      s_sel = wr_setup_i;
      p_sel = wr_pulse_i;
      c_sel = wr_cycle_i;
    end else begin
      s_sel = rd_setup_i;
      p_sel = rd_pulse_i;
      c_sel = rd_cycle_i;
    end
    end_sel = LEN_W'(s_sel) + eff_pulse(p_sel);
  end

  assign setup_o = LEN_W'(s_sel);
  assign pend_o  = end_sel;
  assign len_o   = eff_len(end_sel, c_sel);
  assign over_o  = overrun(end_sel, c_sel);
endmodule

// File: rtl/smem_seq.sv
module smem_seq #(
  parameter int CNT_W = 4,
  parameter int LEN_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             read_i,
  input  logic [LEN_W-1:0] setup_i,
  input  logic [LEN_W-1:0] pend_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CNT_W-1:0] float_i,
  output logic             busy_o,
  output logic             strobe_o,
  output logic             strobe_end_o,
  output logic             last_o,
  output logic             idle_o,
  output logic [CNT_W-1:0] float_cnt_o
);
  logic             busy_q, rd_q;
  logic [LEN_W-1:0] idx_q, setup_q, pend_q, len_q;
  logic [CNT_W-1:0] flt_q;

  assign last_o = busy_q && (idx_q == len_q - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      idx_q   <= '0;
      setup_q <= '0;
      pend_q  <= '0;
      len_q   <= LEN_W'(1);
      flt_q   <= '0;
    end else if (busy_q) begin
      if (last_o) begin
        busy_q <= 1'b0;
        if (rd_q) flt_q <= float_i;
      end else begin
        idx_q <= idx_q + LEN_W'(1);
      end
    end else if (flt_q != '0) begin
      flt_q <= flt_q - CNT_W'(1);
    end else if (start_i) begin
      busy_q  <= 1'b1;
      rd_q    <= read_i;
      idx_q   <= '0;
      setup_q <= setup_i;
      pend_q  <= pend_i;
      len_q   <= len_i;
    end
  end

  assign busy_o       = busy_q;
  assign strobe_o     = busy_q && (idx_q >= setup_q) && (idx_q < pend_q);
  assign strobe_end_o = busy_q && (idx_q == pend_q - LEN_W'(1));
  assign idle_o       = !busy_q && (flt_q == '0);
  assign float_cnt_o  = flt_q;
endmodule

// File: rtl/smem_strobe_gen.sv
module smem_strobe_gen #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_rd_setup,
  input  logic [CNT_W-1:0] cfg_rd_pulse,
  input  logic [CNT_W-1:0] cfg_rd_cycle,
  input  logic [CNT_W-1:0] cfg_wr_setup,
  input  logic [CNT_W-1:0] cfg_wr_pulse,
  input  logic [CNT_W-1:0] cfg_wr_cycle,
  input  logic [CNT_W-1:0] cfg_float,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             mem_cs_n,
  output logic             mem_rd_n,
  output logic             mem_wr_n,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dout,
  output logic             mem_doe,
  input  logic [DW-1:0]    mem_din,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_done,
  output logic             cfg_err
);
  localparam int LEN_W = CNT_W + 2;

  logic [LEN_W-1:0] sel_setup, sel_pend, sel_len;
  logic             sel_over;
  logic             acc_start, seq_busy, seq_strobe, seq_strobe_end, seq_last, seq_idle;
  logic [CNT_W-1:0] flt_cnt;
  logic             wr_q, err_q, done_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, rdata_q;

  assign acc_start = req_valid && seq_idle;

  smem_cfg_sel #(.CNT_W(CNT_W), .LEN_W(LEN_W)) cfg_sel_i (
    .dir_i      (req_write),
    .rd_setup_i (cfg_rd_setup),
    .rd_pulse_i (cfg_rd_pulse),
    .rd_cycle_i (cfg_rd_cycle),
    .wr_setup_i (cfg_wr_setup),
    .wr_pulse_i (cfg_wr_pulse),
    .wr_cycle_i (cfg_wr_cycle),
    .setup_o    (sel_setup),
    .pend_o     (sel_pend),
    .len_o      (sel_len),
    .over_o     (sel_over)
  );

  smem_seq #(.CNT_W(CNT_W), .LEN_W(LEN_W)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (acc_start),
    .read_i       (!req_write),
    .setup_i      (sel_setup),
    .pend_i       (sel_pend),
    .len_i        (sel_len),
    .float_i      (cfg_float),
    .busy_o       (seq_busy),
    .strobe_o     (seq_strobe),
    .strobe_end_o (seq_strobe_end),
    .last_o       (seq_last),
    .idle_o       (seq_idle),
    .float_cnt_o  (flt_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (acc_start) begin
      wr_q    <= req_write;
      err_q   <= sel_over;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= seq_last;
      if (seq_strobe_end && !wr_q) rdata_q <= mem_din;
    end
  end

  assign req_ready = seq_idle;
  assign mem_cs_n  = !seq_busy;
  assign mem_rd_n  = !(seq_strobe && !wr_q);
  assign mem_wr_n  = !(seq_strobe && wr_q);
  assign mem_addr  = addr_q;
  assign mem_dout  = wdata_q;
  assign mem_doe   = seq_busy && wr_q;
  assign rsp_rdata = rdata_q;
  assign rsp_done  = done_q;
  assign cfg_err   = seq_busy && err_q;
endmodule

// File: rtl/smem_strobe_gen_chk.sv
module smem_strobe_gen_chk #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_start,
  input logic [CNT_W-1:0] flt_cnt,
  input logic             req_ready,
  input logic             mem_cs_n,
  input logic             mem_rd_n,
  input logic             mem_wr_n,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_dout,
  input logic             rsp_done,
  input logic             cfg_err
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n)); // R3
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !mem_wr_n) |-> !mem_cs_n); // R3
  AST_START_CS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> !mem_cs_n); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R5
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_dout)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R7
  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_done) |-> (mem_cs_n && $past(!mem_cs_n))); // R7
  AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_cnt != '0) |=> mem_cs_n); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready); // R11
  AST_ERR_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !mem_cs_n); // R10
endmodule

bind smem_strobe_gen smem_strobe_gen_chk #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_start (acc_start),
  .flt_cnt   (flt_cnt),
  .req_ready (req_ready),
  .mem_cs_n  (mem_cs_n),
  .mem_rd_n  (mem_rd_n),
  .mem_wr_n  (mem_wr_n),
  .mem_addr  (mem_addr),
  .mem_dout  (mem_dout),
  .rsp_done  (rsp_done),
  .cfg_err   (cfg_err)
);

// File: tb/smem_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module smem_strobe_gen_tb_top;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] rs, rp, rc, ws, wp, wc, fl;
  logic req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, mem_din;
  logic req_ready, mem_cs_n, mem_rd_n, mem_wr_n, mem_doe, rsp_done, cfg_err;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout, rsp_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  smem_strobe_gen #(.AW(AW), .DW(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_setup(rs), .cfg_rd_pulse(rp), .cfg_rd_cycle(rc),
    .cfg_wr_setup(ws), .cfg_wr_pulse(wp), .cfg_wr_cycle(wc),
    .cfg_float(fl),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_din(mem_din), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .cfg_err(cfg_err)
  );

  // behavioural reference state
  int  m_busy, m_dir, m_k, m_s, m_p, m_c, m_err, m_float, m_done;
  int  m_addr, m_wdata, m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_dir = 0; m_k = 0; m_s = 0; m_p = 1; m_c = 1;
      m_err = 0; m_float = 0; m_done = 0; m_addr = 0; m_wdata = 0; m_rdata = 0;
    end else begin
      int nd;
      nd = 0;
      if (m_busy != 0) begin
        if (m_dir == 0 && m_k == m_s + m_p - 1) m_rdata = int'(mem_din);
        if (m_k == m_c - 1) begin
          m_busy = 0;
          nd = 1;
          if (m_dir == 0) m_float = int'(fl);
        end else m_k = m_k + 1;
      end else if (m_float > 0) begin
        m_float = m_float - 1;
      end else if (req_valid) begin
        int s, p, c;
        m_dir = int'(req_write);
        s = m_dir ? int'(ws) : int'(rs);
        p = m_dir ? int'(wp) : int'(rp);
        c = m_dir ? int'(wc) : int'(rc);
        if (p == 0) p = 1;
        m_s = s; m_p = p;
        m_err = (s + p > c) ? 1 : 0;
        m_c = m_err ? s + p + 1 : c;
        m_addr = int'(req_addr);
        m_wdata = int'(req_wdata);
        m_k = 0;
        m_busy = 1;
      end
      m_done = nd;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int e_rd, e_wr, act_strb;
      e_rd = (m_busy != 0 && m_dir == 0 && m_k >= m_s && m_k < m_s + m_p) ? 0 : 1;
      e_wr = (m_busy != 0 && m_dir == 1 && m_k >= m_s && m_k < m_s + m_p) ? 0 : 1;
      chk(int'(mem_cs_n) == (m_busy ? 0 : 1), "R2 cs window", int'(mem_cs_n), m_busy ? 0 : 1);
      act_strb = int'(mem_rd_n);
      chk(act_strb == e_rd, "R3 read strobe", act_strb, e_rd);
      act_strb = int'(mem_wr_n);
      chk(act_strb == e_wr, "R3 write strobe", act_strb, e_wr);
      if (m_busy != 0 && m_k >= m_s + m_p)
        chk(!mem_cs_n && mem_rd_n && mem_wr_n, "R4 hold phase", int'(mem_cs_n), 0);
      if (m_busy != 0) begin
        chk(int'(mem_addr) == m_addr, "R5 address", int'(mem_addr), m_addr);
        if (m_dir == 1) chk(int'(mem_dout) == m_wdata, "R5 write data", int'(mem_dout), m_wdata);
      end
      chk(int'(mem_doe) == ((m_busy != 0 && m_dir == 1) ? 1 : 0), "R5 drive enable",
          int'(mem_doe), (m_busy != 0 && m_dir == 1) ? 1 : 0);
      chk(int'(rsp_rdata) == m_rdata, "R6 read data", int'(rsp_rdata), m_rdata);
      chk(int'(rsp_done) == m_done, "R7 done pulse", int'(rsp_done), m_done);
      chk(int'(req_ready) == ((m_busy == 0 && m_float == 0) ? 1 : 0), "R8 R11 ready",
          int'(req_ready), (m_busy == 0 && m_float == 0) ? 1 : 0);
      chk(int'(cfg_err) == ((m_busy != 0 && m_err != 0) ? 1 : 0), "R10 error flag",
          int'(cfg_err), (m_busy != 0 && m_err != 0) ? 1 : 0);
    end
  end

  // data bus changes every cycle so a capture on the wrong edge shows
  always @(negedge clk) mem_din <= mem_din + 8'd37;

  task automatic set_cfg(input int a, input int b, input int c, input int d,
                         input int e, input int f, input int g);
    rs = CW'(a); rp = CW'(b); rc = CW'(c);
    ws = CW'(d); wp = CW'(e); wc = CW'(f); fl = CW'(g);
  endtask

  // mode 0: mixed directions, 1: reads only, 2: writes only; gap>0 drops valid periodically
  task automatic drive(input int n, input int mode, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = (gap == 0) ? 1'b1 : ((i % gap) != 0);
      req_write = (mode == 0) ? 1'($urandom % 2) : (mode == 2);
      req_addr  = AW'($urandom);
      req_wdata = DW'($urandom);
    end
  endtask

  initial begin
    set_cfg(1, 3, 5, 1, 3, 5, 2);
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; mem_din = 8'h11;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n && mem_rd_n && mem_wr_n, "R1 strobes idle", int'(mem_cs_n), 1);
    chk(!mem_doe && !rsp_done && !cfg_err, "R1 flags clear", int'(rsp_done), 0);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cs_n && req_ready, "R1 after reset", int'(mem_cs_n), 1);
    drive(120, 0, 0);            // nominal timing, R2 R3 R4 R8
    drive(60, 1, 0);             // back-to-back reads, R6 R8
    drive(60, 2, 0);             // back-to-back writes, R5 R8
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    drive(60, 0, 0);             // pulse floor and stretch, R3 R10
    set_cfg(2, 3, 5, 1, 4, 5, 1);
    drive(80, 0, 3);             // zero hold boundary, R4 R10
    set_cfg(4, 5, 6, 6, 7, 2, 3);
    drive(80, 0, 0);             // overrun sets, R10
    set_cfg(0, 2, 15, 3, 1, 9, 7);
    drive(150, 0, 4);            // long cycles, long float, R8 R11
    set_cfg(2, 1, 4, 0, 6, 15, 0);
    drive(120, 0, 5);            // distinct read/write sets, R9
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule